// File: doc/BRIEF.md
# Link Synchronization Hysteresis Machine

This block decides whether a serial receive link is in lock. Each cycle it may be handed one decoded code group, marked by a valid strobe. Two flags come with the group. One says the group is a synchronization group or ordered set. The other says the group is erroneous. Pattern detection and 8b/10b decoding happen upstream, and only their verdicts arrive here. From these flags the block drives a single sync status line.

Lock is declared only after a programmed number of synchronization groups arrive. Once declared, lock does not drop on the first bad group. Erroneous groups add to an error tally, and every full run of consecutive good groups removes one error from it. Lock is dropped only when the tally reaches its limit. This hysteresis keeps a noisy but usable link from flapping. After lock is lost, the whole acquisition count must be collected again.

The three thresholds are parameters. Their defaults follow a PCIe-style setting: 4 groups to acquire, 17 errors to lose lock and 16 good groups per error removed. A synchronous active-high digital reset holds the machine idle. The search begins on the first cycle after the reset is released.

Top module: `link_sync_fsm`

## Requirements
- R1: While rxDigitalRst is high, and on the first cycle after it falls, syncStatus is 0. Reset clears every count, so a search after reset needs the full acquisition count.
- R2: Cycles with groupValid low change nothing, whatever isSyncGroup and isErrGroup show.
- R3: While out of lock, a valid group with isSyncGroup=1 and isErrGroup=0 adds one to the acquisition count. A valid group with both flags at 0 neither adds to nor clears it. syncStatus rises in the cycle after the ACQ_COUNT-th such group (default 4) is sampled.
- R4: While out of lock, a valid erroneous group (isErrGroup=1) sets the acquisition count back to zero.
- R5: While in lock, each valid erroneous group adds one to the error tally. syncStatus falls in the cycle after the group that brings the tally to LOSS_COUNT (default 17) is sampled.
- R6: While in lock, every GOOD_COUNT (default 16) consecutive valid non-erroneous groups remove one from the error tally. An erroneous group restarts that run at zero.
- R7: The error tally never goes below zero. Good runs completed at a tally of zero bank no credit.
- R8: After lock is lost, the error tally and the acquisition count are cleared. syncStatus stays 0 until ACQ_COUNT fresh synchronization groups arrive.
- R9: A valid group with both isSyncGroup and isErrGroup set counts as erroneous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rxDigitalRst | input | 1 | Synchronous active-high digital reset |
| groupValid | input | 1 | A code group is presented this cycle |
| isSyncGroup | input | 1 | The group is a synchronization group or ordered set |
| isErrGroup | input | 1 | The group is erroneous |
| syncStatus | output | 1 | 1 while the link is in lock |

## Verification
The only visible output is syncStatus, so internal faults show up only at its edges. A wrong acquisition count moves the rising edge earlier or later by whole groups. A wrong error tally or a missed decrement moves the falling edge. A decrement that underflows shows up as loss of lock many groups too late. The bench therefore aims long error bursts and good runs at the exact group on which lock must change. It compares syncStatus against an independent model in the cycle after every group.

// File: rtl/link_sync_pkg.sv
package link_sync_pkg;

  typedef enum logic [1:0] {
    LOSS_OF_SYNC  = 2'd0,
    ACQUIRING     = 2'd1,
    SYNC_ACQUIRED = 2'd2
  } syncState_e;

  typedef struct packed {
    logic syncInc;
    logic syncClr;
    logic errInc;
    logic errDec;
    logic errClr;
    logic goodInc;
    logic goodClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/link_sync_counters.sv
module link_sync_counters
  import link_sync_pkg::*;
#(
  parameter int ACQ_COUNT  = 4,
  parameter int LOSS_COUNT = 17,
  parameter int GOOD_COUNT = 16
) (
  input  logic        clk,
  input  logic        rxDigitalRst,
  input  ctrlStrobe_t strobe,
  output logic        syncHit,
  output logic        errHit,
  output logic        goodHit
);

  localparam int SYNC_W = $clog2(ACQ_COUNT + 1);
  localparam int ERR_W  = $clog2(LOSS_COUNT + 1);
  localparam int GOOD_W = $clog2(GOOD_COUNT + 1);
  localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(ACQ_COUNT - 1);
  localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(LOSS_COUNT - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_COUNT - 1);

  logic [SYNC_W-1:0] syncCnt;
  logic [ERR_W-1:0]  errCnt;
  logic [GOOD_W-1:0] goodCnt;

  // acquisition counter
  always_ff @(posedge clk) begin
    if (rxDigitalRst || strobe.syncClr) syncCnt <= '0;
    else if (strobe.syncInc)            syncCnt <= syncCnt + 1'b1;
  end

  // error tally, saturating at zero on decrement
  always_ff @(posedge clk) begin
    if (rxDigitalRst || strobe.errClr) errCnt <= '0;
    else if (strobe.errInc)            errCnt <= errCnt + 1'b1;
    else if (strobe.errDec && errCnt != '0) errCnt <= errCnt - 1'b1;
  end

  // consecutive good group run
  always_ff @(posedge clk) begin
    if (rxDigitalRst || strobe.goodClr) goodCnt <= '0;
    else if (strobe.goodInc)            goodCnt <= goodCnt + 1'b1;
  end

  assign syncHit = (syncCnt == SYNC_LAST);
  assign errHit  = (errCnt == ERR_LAST);
  assign goodHit = (goodCnt == GOOD_LAST);

  AST_SYNC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rxDigitalRst)
    syncCnt < SYNC_W'(ACQ_COUNT)); // R3
  AST_ERR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rxDigitalRst)
    errCnt < ERR_W'(LOSS_COUNT)); // R5
  AST_GOOD_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rxDigitalRst)
    goodCnt < GOOD_W'(GOOD_COUNT)); // R6
  AST_ERR_FLOOR: assert property (@(posedge clk) disable iff (rxDigitalRst)
    (strobe.errDec && !strobe.errInc && !strobe.errClr && errCnt == '0) |=> errCnt == '0); // R7
  AST_ERR_STEP_DOWN: assert property (@(posedge clk) disable iff (rxDigitalRst)
    (strobe.errDec && !strobe.errInc && !strobe.errClr && errCnt != '0)
      |=> errCnt == $past(errCnt) - 1'b1); // R6

endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl
  import link_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rxDigitalRst,
  input  logic        groupValid,
  input  logic        isSyncGroup,
  input  logic        isErrGroup,
  input  logic        syncHit,
  input  logic        errHit,
  input  logic        goodHit,
  output ctrlStrobe_t strobe,
  output logic        inSync
);

  syncState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rxDigitalRst) state <= LOSS_OF_SYNC;
    else              state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (groupValid) begin
      unique case (state)
        LOSS_OF_SYNC, ACQUIRING: begin
          if (isErrGroup) begin
            strobe.syncClr = 1'b1;
            stateNext      = LOSS_OF_SYNC;
          end else if (isSyncGroup) begin
            if (syncHit) begin
              strobe.syncClr = 1'b1;
              strobe.errClr  = 1'b1;
              strobe.goodClr = 1'b1;
              stateNext      = SYNC_ACQUIRED;
            end else begin
              strobe.syncInc = 1'b1;
              stateNext      = ACQUIRING;
            end
          end
        end
        SYNC_ACQUIRED: begin
          if (isErrGroup) begin
            strobe.goodClr = 1'b1;
            if (errHit) begin
              strobe.syncClr = 1'b1;
              strobe.errClr  = 1'b1;
              stateNext      = LOSS_OF_SYNC;
            end else begin
              strobe.errInc = 1'b1;
            end
          end else if (goodHit) begin
            strobe.goodClr = 1'b1;
            strobe.errDec  = 1'b1;
          end else begin
            strobe.goodInc = 1'b1;
          end
        end
        default: stateNext = LOSS_OF_SYNC;
      endcase
    end
  end

  assign inSync = (state == SYNC_ACQUIRED);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rxDigitalRst)
    !groupValid |=> $stable(state)); // R2
  AST_ACQ_CAUSE: assert property (@(posedge clk) disable iff (rxDigitalRst)
    ($rose(inSync) && !$past(rxDigitalRst)) |-> $past(groupValid && isSyncGroup && !isErrGroup)); // R3
  AST_ERR_CLEARS_ACQ: assert property (@(posedge clk) disable iff (rxDigitalRst)
    (state == ACQUIRING && groupValid && isErrGroup) |=> state == LOSS_OF_SYNC); // R4
  AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (rxDigitalRst)
    ($fell(inSync) && !$past(rxDigitalRst)) |-> $past(groupValid && isErrGroup)); // R5
  AST_BOTH_FLAGS_ERR: assert property (@(posedge clk) disable iff (rxDigitalRst)
    (!inSync && groupValid && isErrGroup && isSyncGroup) |=> !inSync); // R9
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rxDigitalRst)
    state != syncState_e'(2'd3)); // R1

endmodule

// File: rtl/link_sync_fsm.sv
module link_sync_fsm
  import link_sync_pkg::*;
#(
  parameter int ACQ_COUNT  = 4,
  parameter int LOSS_COUNT = 17,
  parameter int GOOD_COUNT = 16
) (
  input  logic clk,
  input  logic rxDigitalRst,
  input  logic groupValid,
  input  logic isSyncGroup,
  input  logic isErrGroup,
  output logic syncStatus
);

  ctrlStrobe_t strobe;
  logic syncHit, errHit, goodHit;

  link_sync_ctrl ctrl_i (
    .clk(clk), .rxDigitalRst(rxDigitalRst), .groupValid(groupValid),
    .isSyncGroup(isSyncGroup), .isErrGroup(isErrGroup),
    .syncHit(syncHit), .errHit(errHit), .goodHit(goodHit),
    .strobe(strobe), .inSync(syncStatus)
  );

  link_sync_counters #(
    .ACQ_COUNT(ACQ_COUNT), .LOSS_COUNT(LOSS_COUNT), .GOOD_COUNT(GOOD_COUNT)
  ) cnt_i (
    .clk(clk), .rxDigitalRst(rxDigitalRst), .strobe(strobe),
    .syncHit(syncHit), .errHit(errHit), .goodHit(goodHit)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rxDigitalRst |=> !syncStatus); // R1

endmodule

// File: tb/link_sync_fsm_tb_top.sv
module link_sync_fsm_tb_top;
  localparam int ACQ  = 4;
  localparam int LOSS = 17;
  localparam int GOOD = 16;

  logic clk = 1'b0;
  logic rxDigitalRst = 1'b1;
  logic groupValid = 1'b0, isSyncGroup = 1'b0, isErrGroup = 1'b0;
  logic syncStatus;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model state
  bit mIn;
  int mSync, mErr, mGood;

  always #5 clk = ~clk;

  link_sync_fsm dut_i (
    .clk(clk), .rxDigitalRst(rxDigitalRst), .groupValid(groupValid),
    .isSyncGroup(isSyncGroup), .isErrGroup(isErrGroup), .syncStatus(syncStatus)
  );

  function automatic void modelReset();
    mIn = 1'b0; mSync = 0; mErr = 0; mGood = 0;
  endfunction

  function automatic void modelStep(bit v, bit s, bit e);
    if (!v) return;
    if (!mIn) begin
      if (e) mSync = 0;
      else if (s) begin
        mSync++;
        if (mSync == ACQ) begin mIn = 1'b1; mSync = 0; mErr = 0; mGood = 0; end
      end
    end else begin
      if (e) begin
        mGood = 0; mErr++;
        if (mErr == LOSS) begin mIn = 1'b0; mErr = 0; mSync = 0; end
      end else begin
        mGood++;
        if (mGood == GOOD) begin mGood = 0; if (mErr > 0) mErr--; end
      end
    end
  endfunction

  task automatic check(string req, bit expv);
    checks++;
    if (syncStatus !== expv) begin
      failures++;
      $display("FAIL %s syncStatus actual=%0b expected=%0b t=%0t", req, syncStatus, expv, $time);
    end
  endtask

  task automatic grp(string req, bit v, bit s, bit e);
    @(negedge clk);
    groupValid = v; isSyncGroup = s; isErrGroup = e;
    @(posedge clk);
    modelStep(v, s, e);
    #2;
    check(req, mIn);
  endtask

  task automatic doReset();
    @(negedge clk);
    rxDigitalRst = 1'b1; groupValid = 1'b0;
    @(posedge clk); #2;
    modelReset();
    check("R1", 1'b0);
    @(negedge clk);
    rxDigitalRst = 1'b0;
    @(posedge clk); #2;
    check("R1", 1'b0);
  endtask

  task automatic acquire();
    for (int i = 0; i < ACQ; i++) grp("R3", 1, 1, 0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    modelReset();
    repeat (3) @(posedge clk);
    #2 check("R1", 1'b0);
    doReset();

    // R3: three sync groups short of lock, fourth acquires; plain good groups are neutral
    for (int i = 0; i < ACQ - 1; i++) grp("R3", 1, 1, 0);
    grp("R3", 1, 0, 0);
    grp("R3", 1, 1, 0);
    if (!syncStatus) begin failures++; $display("FAIL R3 lock not taken on 4th group actual=0 expected=1"); end
    checks++;

    // R1: reset while locked forces full reacquisition
    doReset();
    for (int i = 0; i < ACQ - 1; i++) grp("R1", 1, 1, 0);
    grp("R1", 1, 1, 0);

    // R4: error in the middle of acquisition restarts count
    doReset();
    grp("R4", 1, 1, 0); grp("R4", 1, 1, 0);
    grp("R4", 1, 0, 1);
    for (int i = 0; i < ACQ - 1; i++) grp("R4", 1, 1, 0);
    grp("R4", 1, 1, 0);

    // R2: invalid cycles with flags set do nothing
    doReset();
    for (int i = 0; i < 8; i++) grp("R2", 0, 1, 0);
    acquire();
    for (int i = 0; i < 40; i++) grp("R2", 0, 0, 1);

    // R5: 16 errors keep lock, 17th drops it
    for (int i = 0; i < LOSS - 1; i++) grp("R5", 1, 0, 1);
    grp("R5", 1, 0, 1);

    // R8: after loss, full reacquisition needed; R9 both flags count as error
    for (int i = 0; i < ACQ - 1; i++) grp("R8", 1, 1, 0);
    grp("R9", 1, 1, 1);
    for (int i = 0; i < ACQ - 1; i++) grp("R9", 1, 1, 0);
    grp("R8", 1, 1, 0);

    // R6: 16 errors, one good run, then two more errors needed
    for (int i = 0; i < LOSS - 1; i++) grp("R6", 1, 0, 1);
    for (int i = 0; i < GOOD; i++) grp("R6", 1, 0, 0);
    grp("R6", 1, 0, 1);
    grp("R6", 1, 0, 1);
    // R6: an error inside a good run restarts it
    acquire();
    for (int i = 0; i < LOSS - 1; i++) grp("R6", 1, 0, 1);
    for (int i = 0; i < GOOD - 1; i++) grp("R6", 1, 0, 0);
    grp("R6", 1, 0, 1);

    // R7: good runs at zero errors bank nothing
    acquire();
    for (int i = 0; i < 3 * GOOD; i++) grp("R7", 1, 1, 0);
    for (int i = 0; i < LOSS; i++) grp("R7", 1, 0, 1);

    // random phases with varying error density
    for (int ph = 0; ph < 30; ph++) begin
      int errPct = (ph % 3 == 0) ? 3 : ((ph % 3 == 1) ? 12 : 45);
      for (int i = 0; i < 150; i++) begin
        bit v = ($urandom % 100) < 85;
        bit e = ($urandom % 100) < errPct;
        bit s = ($urandom % 100) < 60;
        grp("R5", v, s, e);
      end
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule